// File: doc/BRIEF.md
# Chained DMA Descriptor Decoder with Byte-Lane Swap

This block sits in front of an XOR/copy engine and turns a 64-byte descriptor, fetched from memory as eight 64-bit beats over a valid/ready stream, into named fields. The engine reads these fields directly: status word, CRC result, link to the next descriptor, command word, destination address, byte count and eight source addresses. The block also flags the end of a chain and marks which sources take part in an XOR.

A mode input lets a big-endian host lay out descriptors in its own byte order. In that mode every 8-byte beat is byte-reversed before decoding. As a result, each pair of adjacent 32-bit words swaps places in memory, and logical source i sits in the neighbouring physical slot. The mode is captured on the first beat of each descriptor.

A separate combinational write-back path packs an updated status word and CRC word into the first beat of the descriptor. It uses the same byte rule, so the engine can store that beat back in the host's byte order.

Top module: `xdp_desc_parser`

## Requirements
- R1: During and straight after synchronous reset, in_ready is 1, done is 0, every decoded field and src_addr is 0, and last is 1.
- R2: Beat k (k = 0..7) carries descriptor word 2k in bits 31:0 and word 2k+1 in bits 63:32. The word order is status (0), CRC (1), next pointer (2), command (3), destination (4), byte count (5), sources 0..7 (6..13) and two reserved words (14, 15) that are ignored. With swap_en = 0 the beats are decoded exactly as received.
- R3: With swap_en = 1, each beat is byte-reversed (byte j, bits 8j+7:8j, moves to byte 7-j) before it is split into words. In host memory this places CRC before status, command before next pointer and byte count before destination, and it puts logical source i at physical word 6 + (i XOR 1).
- R4: The swap mode is sampled when the first beat of a descriptor is accepted. A change of swap_en while beats 1..7 of that descriptor are arriving has no effect on how they are decoded.
- R5: done is high for exactly one cycle: the cycle right after the eighth beat of a descriptor is accepted.
- R6: in_ready is 0 while done is high. A beat offered in that cycle is held and is accepted in the following cycle.
- R7: src_sel equals command word bits 7:0, and bit i set marks source i as taking part in the XOR.
- R8: last is 1 exactly when the decoded next pointer is zero.
- R9: The decoded fields keep their values from the done cycle until the next beat is accepted.
- R10: wb_beat equals {wb_crc, wb_status} when swap_en = 0, and the byte reversal of that value when swap_en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Byte-reverse each 8-byte beat (host is big-endian) |
| in_valid | input | 1 | Descriptor beat is offered |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 64 | Descriptor beat as stored in memory |
| done | output | 1 | One-cycle pulse: a full descriptor has been decoded |
| last | output | 1 | Next pointer is zero (end of chain) |
| status | output | 32 | Decoded status word |
| crc | output | 32 | Decoded CRC result word |
| next_ptr | output | 32 | Decoded next-descriptor pointer |
| cmd | output | 32 | Decoded command word |
| dst_addr | output | 32 | Decoded destination address |
| byte_cnt | output | 32 | Decoded byte count |
| src_addr | output | 256 | Logical source addresses; source i in bits 32i+31:32i |
| src_sel | output | 8 | Sources that take part in the XOR (command bits 7:0) |
| wb_status | input | 32 | Status word to write back |
| wb_crc | input | 32 | CRC word to write back |
| wb_beat | output | 64 | Packed first beat for write-back, in memory byte order |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the done pulse of one descriptor and the first beat of the next. The bench provokes this by holding in_valid high across two descriptors. It then checks three things: in_ready is low in the done cycle, the fields in that cycle still belong to the first descriptor, and the held beat still decodes correctly as part of the second. The second pair is a swap_en change in the middle of a descriptor, while the write-back packing reacts to swap_en at once. The bench toggles the mode after the first beat and checks that decoding keeps the latched mode.

// File: rtl/xdp_pkg.sv
package xdp_pkg;

    localparam int WORD_W    = 32;
    localparam int BEAT_W    = 2 * WORD_W;
    localparam int NUM_WORDS = 16;
    localparam int NUM_BEATS = NUM_WORDS / 2;
    localparam int NUM_SRC   = 8;

    // word slots in the logical (little-endian) layout
    localparam int W_STATUS = 0;
    localparam int W_CRC    = 1;
    localparam int W_NEXT   = 2;
    localparam int W_CMD    = 3;
    localparam int W_DST    = 4;
    localparam int W_BCNT   = 5;
    localparam int W_SRC0   = 6;

    // beats that hold words the engine uses; the rest are reserved
    localparam int USED_BEATS = (W_SRC0 + NUM_SRC + 1) / 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t status;
        word_t crc;
        word_t next_ptr;
        word_t cmd;
        word_t dst_addr;
        word_t byte_cnt;
    } hdr_t;

endpackage

// File: rtl/xdp_lane_swap.sv
module xdp_lane_swap #(
    parameter int W = 64
) (
    input  logic         swap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = swap ? din[8*(NBYTES-1-b) +: 8] : din[8*b +: 8];
    end
endmodule

// File: rtl/xdp_beat_ctrl.sv
module xdp_beat_ctrl #(
    parameter int NUM_BEATS = 8,
    localparam int IDX_W = $clog2(NUM_BEATS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             swap_en,
    output logic             in_ready,
    output logic             accept,
    output logic [IDX_W-1:0] beat_idx,
    output logic             mode,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BEATS - 1);

    logic [IDX_W-1:0] idx_q;
    logic             pend_q;
    logic             mode_q;

    assign in_ready = !pend_q;
    assign accept   = in_valid && in_ready;
    assign beat_idx = idx_q;
    assign mode     = (idx_q == '0) ? swap_en : mode_q;
    assign done     = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            pend_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            pend_q <= accept && (idx_q == LAST_IDX);
            if (accept) begin
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                if (idx_q == '0) begin
                    mode_q <= swap_en;
                end
            end
        end
    end
endmodule

// File: rtl/xdp_desc_store.sv
module xdp_desc_store #(
    parameter int BEAT_W     = 64,
    parameter int USED_BEATS = 7,
    parameter int IDX_W      = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              accept,
    input  logic [IDX_W-1:0]                  beat_idx,
    input  logic [BEAT_W-1:0]                 beat_in,
    output logic [USED_BEATS-1:0][BEAT_W-1:0] slots
);
    logic [USED_BEATS-1:0][BEAT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            for (int k = 0; k < USED_BEATS; k++) begin
                if (accept && beat_idx == IDX_W'(k)) begin
                    slot_q[k] <= beat_in;
                end
            end
        end
    end

    assign slots = slot_q;
endmodule

// File: rtl/xdp_desc_parser.sv
module xdp_desc_parser
    import xdp_pkg::*;
#(
    parameter int WORD_W  = xdp_pkg::WORD_W,
    parameter int NUM_SRC = xdp_pkg::NUM_SRC,
    localparam int BEAT_W = 2 * WORD_W,
    localparam int IDX_W  = $clog2(NUM_BEATS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      swap_en,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [BEAT_W-1:0]         in_data,
    output logic                      done,
    output logic                      last,
    output logic [WORD_W-1:0]         status,
    output logic [WORD_W-1:0]         crc,
    output logic [WORD_W-1:0]         next_ptr,
    output logic [WORD_W-1:0]         cmd,
    output logic [WORD_W-1:0]         dst_addr,
    output logic [WORD_W-1:0]         byte_cnt,
    output logic [NUM_SRC*WORD_W-1:0] src_addr,
    output logic [NUM_SRC-1:0]        src_sel,
    input  logic [WORD_W-1:0]         wb_status,
    input  logic [WORD_W-1:0]         wb_crc,
    output logic [BEAT_W-1:0]         wb_beat
);
    localparam int N_USED = (W_SRC0 + NUM_SRC + 1) / 2;

    logic              accept;
    logic [IDX_W-1:0]  beat_idx;
    logic              mode;
    logic [BEAT_W-1:0] beat_log;

    logic [N_USED-1:0][BEAT_W-1:0]   slots;
    logic [2*N_USED-1:0][WORD_W-1:0] words;
    hdr_t                            hdr;

    xdp_beat_ctrl #(.NUM_BEATS(NUM_BEATS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .swap_en  (swap_en),
        .in_ready (in_ready),
        .accept   (accept),
        .beat_idx (beat_idx),
        .mode     (mode),
        .done     (done)
    );

    xdp_lane_swap #(.W(BEAT_W)) u_rx_swap (
        .swap (mode),
        .din  (in_data),
        .dout (beat_log)
    );

    xdp_desc_store #(
        .BEAT_W     (BEAT_W),
        .USED_BEATS (N_USED),
        .IDX_W      (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .beat_idx (beat_idx),
        .beat_in  (beat_log),
        .slots    (slots)
    );

    assign words = slots;

    always_comb begin
        hdr.status   = words[W_STATUS];
        hdr.crc      = words[W_CRC];
        hdr.next_ptr = words[W_NEXT];
        hdr.cmd      = words[W_CMD];
        hdr.dst_addr = words[W_DST];
        hdr.byte_cnt = words[W_BCNT];
    end

    assign status   = hdr.status;
    assign crc      = hdr.crc;
    assign next_ptr = hdr.next_ptr;
    assign cmd      = hdr.cmd;
    assign dst_addr = hdr.dst_addr;
    assign byte_cnt = hdr.byte_cnt;
    assign last     = (hdr.next_ptr == '0);
    assign src_sel  = hdr.cmd[NUM_SRC-1:0];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_addr[WORD_W*i +: WORD_W] = words[W_SRC0 + i];
    end

    xdp_lane_swap #(.W(BEAT_W)) u_wb_swap (
        .swap (swap_en),
        .din  ({wb_crc, wb_status}),
        .dout (wb_beat)
    );
endmodule

// File: rtl/xdp_desc_parser_chk.sv
module xdp_desc_parser_chk
    import xdp_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      swap_en,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic                      done,
    input logic [WORD_W-1:0]         status,
    input logic [WORD_W-1:0]         next_ptr,
    input logic [NUM_SRC*WORD_W-1:0] src_addr,
    input logic [WORD_W-1:0]         wb_status,
    input logic [WORD_W-1:0]         wb_crc,
    input logic [BEAT_W-1:0]         wb_beat
);
    // R6
    ready_low_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R5
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_ready));

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(status) && $stable(next_ptr) && $stable(src_addr)));

    // R10
    wb_swapped_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        swap_en |-> (wb_beat[7:0] == wb_crc[31:24] && wb_beat[63:56] == wb_status[7:0]));

    // R10
    wb_plain_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !swap_en |-> (wb_beat[31:0] == wb_status && wb_beat[63:32] == wb_crc));
endmodule

bind xdp_desc_parser xdp_desc_parser_chk u_chk (.*);

// File: tb/xdp_desc_parser_bench.sv
module xdp_desc_parser_bench;
    localparam int CLK_PERIOD = 10;

    typedef logic [15:0][31:0] dwords_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         swap_en;
    logic         in_valid;
    logic         in_ready;
    logic [63:0]  in_data;
    logic         done;
    logic         last;
    logic [31:0]  status, crc, next_ptr, cmd, dst_addr, byte_cnt;
    logic [255:0] src_addr;
    logic [7:0]   src_sel;
    logic [31:0]  wb_status, wb_crc;
    logic [63:0]  wb_beat;

    int n_checks = 0;
    int n_fail   = 0;

    dwords_t exp_q[$];
    string   tag_q[$];
    dwords_t last_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    xdp_desc_parser u_xdp_desc_parser (
        .clk(clk), .rst(rst), .swap_en(swap_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .done(done), .last(last), .status(status), .crc(crc),
        .next_ptr(next_ptr), .cmd(cmd), .dst_addr(dst_addr),
        .byte_cnt(byte_cnt), .src_addr(src_addr), .src_sel(src_sel),
        .wb_status(wb_status), .wb_crc(wb_crc), .wb_beat(wb_beat)
    );

    function automatic logic [63:0] brev(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
        return r;
    endfunction

    function automatic dwords_t mk(input int seed, input logic [31:0] nxt);
        dwords_t w;
        for (int i = 0; i < 16; i++)
            w[i] = {8'(seed), 8'(i), 16'hA5C3 ^ 16'(i * seed * 7)};
        w[2] = nxt;
        return w;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // driver: pushes the expected item, then offers the eight beats
    task automatic send_desc(input dwords_t w, input logic swp,
                             input logic toggle, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
        last_w = w;
        for (int k = 0; k < 8; k++) begin
            logic [63:0] lb;
            lb = {w[2*k+1], w[2*k]};
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = swp ? brev(lb) : lb;
            swap_en  = (toggle && k > 0) ? ~swp : swp;
            while (!in_ready) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: R5 timing, R6 ready, field comparison against the queue
    int   mon_cnt  = 0;
    logic exp_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done !== exp_done) begin
                n_checks++;
                n_fail++;
                $display("FAIL R5 done pulse: actual %b expected %b", done, exp_done);
            end else if (exp_done) begin
                n_checks++;
            end
            if (done) begin
                chk("R6", "in_ready during done", {63'd0, in_ready}, 64'd0);
                if (exp_q.size() == 0) begin
                    chk("R5", "unexpected descriptor", 64'd1, 64'd0);
                end else begin
                    dwords_t w;
                    string   t;
                    w = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, "status",   {32'd0, status},   {32'd0, w[0]});
                    chk(t, "crc",      {32'd0, crc},      {32'd0, w[1]});
                    chk(t, "next_ptr", {32'd0, next_ptr}, {32'd0, w[2]});
                    chk(t, "cmd",      {32'd0, cmd},      {32'd0, w[3]});
                    chk(t, "dst_addr", {32'd0, dst_addr}, {32'd0, w[4]});
                    chk(t, "byte_cnt", {32'd0, byte_cnt}, {32'd0, w[5]});
                    for (int i = 0; i < 8; i++)
                        chk(t, "src_addr", {32'd0, src_addr[32*i +: 32]}, {32'd0, w[6+i]});
                    chk("R7", "src_sel", {56'd0, src_sel}, {56'd0, w[3][7:0]});
                    chk("R8", "last", {63'd0, last}, {63'd0, (w[2] == 32'd0)});
                end
            end
            if (in_valid && in_ready) begin
                exp_done = (mon_cnt == 7);
                mon_cnt  = (mon_cnt + 1) % 8;
            end else begin
                exp_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        dwords_t wa, wb, wc, wd, we, wf, wg;
        rst = 1'b1; swap_en = 1'b0; in_valid = 1'b0; in_data = '0;
        wb_status = '0; wb_crc = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "in_ready", {63'd0, in_ready}, 64'd1);
        chk("R1", "done",     {63'd0, done},     64'd0);
        chk("R1", "status",   {32'd0, status},   64'd0);
        chk("R1", "src_addr", src_addr[63:0],    64'd0);
        chk("R1", "last",     {63'd0, last},     64'd1);
        rst = 1'b0;

        wa = mk(3, 32'h0000_1040);  wa[3] = 32'h0001_00A5;
        send_desc(wa, 1'b0, 1'b0, "R2");
        idle(4);
        // R9 fields hold while nothing is accepted
        chk("R9", "status hold",   {32'd0, status},   {32'd0, last_w[0]});
        chk("R9", "next_ptr hold", {32'd0, next_ptr}, {32'd0, last_w[2]});
        chk("R9", "src7 hold",     {32'd0, src_addr[255:224]}, {32'd0, last_w[13]});

        wb = mk(5, 32'hDEAD_0080);  wb[3] = 32'h0000_005A;
        send_desc(wb, 1'b1, 1'b0, "R3");
        idle(3);

        wc = mk(9, 32'h0);  wc[5] = 32'hFFFF_FFFF;
        send_desc(wc, 1'b0, 1'b0, "R8");
        idle(3);

        // R6 / R5: back-to-back with valid held high
        wd = mk(11, 32'h0000_2000);  wd[3] = 32'h0000_00FF;
        we = mk(13, 32'h0);
        send_desc(wd, 1'b1, 1'b0, "R6");
        send_desc(we, 1'b0, 1'b0, "R6");
        idle(3);

        // R4: swap_en flips after the first beat
        wf = mk(17, 32'h0000_3000);
        send_desc(wf, 1'b0, 1'b1, "R4");
        idle(3);
        wg = mk(19, 32'h0000_4000);  wg[3] = 32'h0000_0081;
        send_desc(wg, 1'b1, 1'b1, "R4");
        idle(3);

        // R10 write-back packing
        @(negedge clk);
        swap_en = 1'b0; wb_status = 32'h1122_3344; wb_crc = 32'h5566_7788;
        #1;
        chk("R10", "wb plain", wb_beat, 64'h5566_7788_1122_3344);
        @(negedge clk);
        swap_en = 1'b1;
        #1;
        chk("R10", "wb swapped", wb_beat, brev(64'h5566_7788_1122_3344));
        @(negedge clk);
        wb_status = 32'hCAFE_0001; wb_crc = 32'h0BAD_F00D;
        #1;
        chk("R10", "wb swapped 2", wb_beat, brev({32'h0BAD_F00D, 32'hCAFE_0001}));

        idle(4);
        chk("R5", "all descriptors seen", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule